// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block holds the control state a small in-order core needs to enter and leave a trap handler. It owns the machine status word and two save registers. It watches the pending trap sources and the core's instruction-boundary strobe. When it accepts a trap, it writes the next-instruction address and the old status word into the save registers. In the same clock it clears the masked status bits and issues a fetch redirect to a vector picked from the trap's cause code.

A return strobe reverses the entry. The saved status word goes back into the status register, and fetch is redirected to the saved address. Software reaches all three registers through a small select/write/read port.

Trap sources, in priority order:
- a reset request, which cannot be masked;
- any number of synchronous exception lines, each carrying its own cause code;
- one external interrupt line, gated by the enable bit in the status word.

Top module: `trap_ctl`

## Requirements
- R1: After reset the status word equals `MSR_RST`, both save registers read 0, and `redirect` is low.
- R2: A trap is accepted only in a cycle where `boundary` is 1. With `boundary` at 0, no source changes the status word or the save registers, and none causes a redirect.
- R3: On acceptance, save register 0 receives `pc_next` and save register 1 receives the status word as it was before that edge.
- R4: On acceptance, the status word becomes its old value with every bit of `CLR_MASK` cleared. The external enable bit, at bit position `EE_BIT` (16 by default), is always among the bits cleared.
- R5: With the enable bit at 0, `ext_irq` is ignored. With it at 1, `ext_irq` at a boundary is accepted.
- R6: `reset_req` at a boundary is accepted whatever the enable bit holds.
- R7: Priority is `reset_req` first, then `sync_req` with the lowest index first, then `ext_irq`.
- R8: The redirect target is `VEC_BASE + cause * 0x100`. The reset cause is `RESET_CAUSE` (1) and the external cause is `EXT_CAUSE` (5). Synchronous line i supplies its cause in bits [i*CAUSE_W +: CAUSE_W] of `sync_cause`.
- R9: `redirect` is high for exactly the one cycle after an accepted trap or return, with `target_pc` valid in that cycle.
- R10: A return (`rfi` high with no trap accepted in that cycle) copies save register 1 into the status word and redirects to the address in save register 0. Both save registers keep their values.
- R11: If a trap is accepted in the same cycle as `rfi`, the trap is taken and the return is dropped.
- R12: The register port selects with `reg_sel` (0 status word, 1 save register 0, 2 save register 1, 3 reads 0). Writes land on the next edge. A write in a cycle with a trap entry or a return is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_next | input | XLEN | Address of the next instruction |
| boundary | input | 1 | Core is between two instructions |
| ext_irq | input | 1 | External interrupt request |
| reset_req | input | 1 | Unmaskable reset trap request |
| sync_req | input | N_SYNC | Synchronous exception requests |
| sync_cause | input | N_SYNC*CAUSE_W | Cause code per synchronous line |
| rfi | input | 1 | Return-from-trap strobe |
| reg_wr | input | 1 | Register port write enable |
| reg_sel | input | 2 | Register port select |
| reg_wdata | input | XLEN | Register port write data |
| reg_rdata | output | XLEN | Register port read data |
| msr | output | XLEN | Current status word |
| redirect | output | 1 | One-cycle fetch redirect |
| target_pc | output | XLEN | Redirect address |

## Verification
The bench builds the block with three synchronous lines, a nonzero vector base of 0xFFF00000, and a clear mask that covers bit 4 as well as the enable bit. This makes it possible to check lowest-index arbitration among several synchronous lines. It also shows that a second masked bit is cleared on entry while other bits survive. Because each source has a distinct cause code, an arbitration error shows up directly in the vector address.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [1:0] {
      SEL_MSR  = 2'd0,
      SEL_SAV0 = 2'd1,
      SEL_SAV1 = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int VEC_SHIFT = 8;
endpackage

// File: rtl/trap_arb.sv
module trap_arb #(
   parameter int N_SYNC      = 2,
   parameter int CAUSE_W     = 4,
   parameter int RESET_CAUSE = 1,
   parameter int EXT_CAUSE   = 5
) (
   input  logic                        reset_req,
   input  logic [N_SYNC-1:0]           sync_req,
   input  logic [N_SYNC*CAUSE_W-1:0]   sync_cause,
   input  logic                        ext_irq,
   input  logic                        ext_en,
   output logic                        hit,
   output logic [CAUSE_W-1:0]          cause
);
   logic [N_SYNC:0]   seen;
   logic [N_SYNC-1:0] win;
   logic              any_sync;

   assign seen[0] = 1'b0;
   for (genvar g = 0; g < N_SYNC; g++) begin : g_slot
      assign win[g]    = sync_req[g] & ~seen[g];
      assign seen[g+1] = seen[g] | sync_req[g];
   end
   assign any_sync = seen[N_SYNC];

   always_comb begin
      logic [CAUSE_W-1:0] sc;
      sc = '0;
      for (int i = 0; i < N_SYNC; i++)
         if (win[i]) sc = sc | sync_cause[i*CAUSE_W +: CAUSE_W];
      if (reset_req)           cause = CAUSE_W'(RESET_CAUSE);
      else if (any_sync)       cause = sc;
      else                     cause = CAUSE_W'(EXT_CAUSE);
   end

   assign hit = reset_req | any_sync | (ext_irq & ext_en);
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
   parameter int              XLEN     = 32,
   parameter int              CAUSE_W  = 4,
   parameter logic [XLEN-1:0] VEC_BASE = '0
) (
   input  logic [CAUSE_W-1:0] cause,
   output logic [XLEN-1:0]    vec
);
   import trap_pkg::*;
   localparam int              SPAN     = CAUSE_W + VEC_SHIFT;
   localparam logic [XLEN-1:0] LOW_MASK = (XLEN'(1) << SPAN) - XLEN'(1);
   localparam bit              ALIGNED  = (VEC_BASE & LOW_MASK) == '0;

   logic [XLEN-1:0] offs;
   assign offs = XLEN'(cause) << VEC_SHIFT;

   if (ALIGNED) begin : g_or
      assign vec = VEC_BASE | offs;
   end else begin : g_add
      assign vec = VEC_BASE + offs;
   end
endmodule

// File: rtl/trap_regs.sv
module trap_regs #(
   parameter int              XLEN     = 32,
   parameter int              EE_BIT   = 16,
   parameter logic [XLEN-1:0] CLR_MASK = '0,
   parameter logic [XLEN-1:0] MSR_RST  = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take,
   input  logic                  ret,
   input  logic [XLEN-1:0]       pc_next,
   input  logic [XLEN-1:0]       vec,
   input  logic                  reg_wr,
   input  trap_pkg::reg_sel_e    reg_sel,
   input  logic [XLEN-1:0]       reg_wdata,
   output logic [XLEN-1:0]       msr,
   output logic [XLEN-1:0]       sav0,
   output logic [XLEN-1:0]       sav1,
   output logic                  redirect,
   output logic [XLEN-1:0]       target_pc
);
   import trap_pkg::*;
   localparam logic [XLEN-1:0] CLR_ALL = CLR_MASK | (XLEN'(1) << EE_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msr       <= MSR_RST;
         sav0      <= '0;
         sav1      <= '0;
         redirect  <= 1'b0;
         target_pc <= '0;
      end else begin
         redirect <= take | ret;
         if (take) begin
            sav0      <= pc_next;
            sav1      <= msr;
            msr       <= msr & ~CLR_ALL;
            target_pc <= vec;
         end else if (ret) begin
            msr       <= sav1;
            target_pc <= sav0;
         end else if (reg_wr) begin
            case (reg_sel)
               SEL_MSR:  msr  <= reg_wdata;
               SEL_SAV0: sav0 <= reg_wdata;
               SEL_SAV1: sav1 <= reg_wdata;
               default:  ;
            endcase
         end
      end
   end
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl #(
   parameter int              XLEN        = 32,
   parameter int              EE_BIT      = 16,
   parameter int              N_SYNC      = 2,
   parameter int              CAUSE_W     = 4,
   parameter int              RESET_CAUSE = 1,
   parameter int              EXT_CAUSE   = 5,
   parameter logic [XLEN-1:0] VEC_BASE    = '0,
   parameter logic [XLEN-1:0] CLR_MASK    = '0,
   parameter logic [XLEN-1:0] MSR_RST     = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [XLEN-1:0]           pc_next,
   input  logic                      boundary,
   input  logic                      ext_irq,
   input  logic                      reset_req,
   input  logic [N_SYNC-1:0]         sync_req,
   input  logic [N_SYNC*CAUSE_W-1:0] sync_cause,
   input  logic                      rfi,
   input  logic                      reg_wr,
   input  logic [1:0]                reg_sel,
   input  logic [XLEN-1:0]           reg_wdata,
   output logic [XLEN-1:0]           reg_rdata,
   output logic [XLEN-1:0]           msr,
   output logic                      redirect,
   output logic [XLEN-1:0]           target_pc
);
   import trap_pkg::*;

   if (EE_BIT >= XLEN) begin : g_bad_ee
      $error("EE_BIT outside status word");
   end
   if (CAUSE_W + VEC_SHIFT > XLEN) begin : g_bad_cw
      $error("cause field too wide for XLEN");
   end
   if (N_SYNC < 1) begin : g_bad_ns
      $error("N_SYNC must be at least 1");
   end
   if (RESET_CAUSE >= (1 << CAUSE_W) || EXT_CAUSE >= (1 << CAUSE_W)) begin : g_bad_cc
      $error("fixed cause code does not fit CAUSE_W");
   end

   logic               hit, take, ret;
   logic [CAUSE_W-1:0] cause;
   logic [XLEN-1:0]    vec, sav0, sav1;
   reg_sel_e           sel;

   assign sel = reg_sel_e'(reg_sel);

   trap_arb #(
      .N_SYNC(N_SYNC), .CAUSE_W(CAUSE_W),
      .RESET_CAUSE(RESET_CAUSE), .EXT_CAUSE(EXT_CAUSE)
   ) u_arb (
      .reset_req(reset_req), .sync_req(sync_req), .sync_cause(sync_cause),
      .ext_irq(ext_irq), .ext_en(msr[EE_BIT]), .hit(hit), .cause(cause)
   );

   trap_vec #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_BASE(VEC_BASE)) u_vec (
      .cause(cause), .vec(vec)
   );

   assign take = boundary & hit;
   assign ret  = rfi & ~take;

   trap_regs #(
      .XLEN(XLEN), .EE_BIT(EE_BIT), .CLR_MASK(CLR_MASK), .MSR_RST(MSR_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .take(take), .ret(ret), .pc_next(pc_next),
      .vec(vec), .reg_wr(reg_wr), .reg_sel(sel), .reg_wdata(reg_wdata),
      .msr(msr), .sav0(sav0), .sav1(sav1), .redirect(redirect),
      .target_pc(target_pc)
   );

   always_comb begin
      case (sel)
         SEL_MSR:  reg_rdata = msr;
         SEL_SAV0: reg_rdata = sav0;
         SEL_SAV1: reg_rdata = sav1;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/trap_ctl_chk.sv
module trap_ctl_chk #(
   parameter int              XLEN        = 32,
   parameter int              EE_BIT      = 16,
   parameter int              N_SYNC      = 2,
   parameter int              RESET_CAUSE = 1,
   parameter logic [XLEN-1:0] VEC_BASE    = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [XLEN-1:0]   pc_next,
   input logic              boundary,
   input logic              reset_req,
   input logic [N_SYNC-1:0] sync_req,
   input logic              rfi,
   input logic [XLEN-1:0]   msr,
   input logic [XLEN-1:0]   sav0,
   input logic [XLEN-1:0]   sav1,
   input logic              redirect,
   input logic [XLEN-1:0]   target_pc
);
   localparam logic [XLEN-1:0] RST_TGT = VEC_BASE + (XLEN'(RESET_CAUSE) << 8);

   logic armed;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;

   // R2 / R9: no boundary and no return means no redirect next cycle
   assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !boundary && !rfi |=> !redirect);

   // R3: entry saves next PC and old status word
   assert_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
      armed && boundary && reset_req |=> sav0 == $past(pc_next) && sav1 == $past(msr));

   // R4 / R6: reset entry clears enable bit and always redirects
   assert_clear_ee_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && boundary && reset_req |=> redirect && !msr[EE_BIT]);

   // R8: reset vector
   assert_reset_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      armed && boundary && reset_req |=> target_pc == RST_TGT);

   // R5: masked external line alone causes nothing
   assert_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      armed && boundary && !reset_req && sync_req == '0 && !msr[EE_BIT] && !rfi
      |=> !redirect);

   // R10: plain return restores status word and jumps to saved address
   assert_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
      armed && rfi && !boundary
      |=> redirect && msr == $past(sav1) && target_pc == $past(sav0));
endmodule

bind trap_ctl trap_ctl_chk #(
   .XLEN(XLEN), .EE_BIT(EE_BIT), .N_SYNC(N_SYNC),
   .RESET_CAUSE(RESET_CAUSE), .VEC_BASE(VEC_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pc_next(pc_next), .boundary(boundary),
   .reset_req(reset_req), .sync_req(sync_req), .rfi(rfi), .msr(msr),
   .sav0(sav0), .sav1(sav1), .redirect(redirect), .target_pc(target_pc)
);

// File: tb/trap_ctl_test.sv
module trap_ctl_test;
   localparam int          XLEN = 32;
   localparam int          NS   = 3;
   localparam int          CW   = 4;
   localparam logic [31:0] K0   = 32'h0000_4440;
   localparam logic [31:0] K1   = 32'h0001_8032;

   typedef struct packed {
      logic [31:0] msr_i;
      logic [31:0] pc;
      logic        bnd;
      logic        ext;
      logic        rreq;
      logic [2:0]  sreq;
      logic        rfi;
      logic        take;
      logic        redir;
      logic [31:0] tgt;
      logic [31:0] msr_e;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{32'h0001_0033, 32'h100, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1, 32'hFFF0_0500, 32'h0000_0023},
      '{32'h0000_0033, 32'h200, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0000_0033},
      '{32'h0000_0002, 32'h300, 1'b1, 1'b0, 1'b1, 3'b000, 1'b0, 1'b1, 1'b1, 32'hFFF0_0100, 32'h0000_0002},
      '{32'h0001_0012, 32'h400, 1'b0, 1'b1, 1'b1, 3'b111, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0001_0012},
      '{32'h0001_0000, 32'h500, 1'b1, 1'b1, 1'b0, 3'b110, 1'b0, 1'b1, 1'b1, 32'hFFF0_0700, 32'h0000_0000},
      '{32'h0001_0000, 32'h600, 1'b1, 1'b0, 1'b1, 3'b111, 1'b0, 1'b1, 1'b1, 32'hFFF0_0100, 32'h0000_0000},
      '{32'h0001_0FFF, 32'h700, 1'b1, 1'b0, 1'b0, 3'b100, 1'b0, 1'b1, 1'b1, 32'hFFF0_0900, 32'h0000_0FEF},
      '{32'h0000_0005, 32'h800, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 1'b1, K0,            K1},
      '{32'h0001_0001, 32'h900, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1, 1'b1, 1'b1, 32'hFFF0_0500, 32'h0000_0001},
      '{32'h0000_0001, 32'hA00, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0, 1'b1, K0,            K1},
      '{32'h0001_0000, 32'hB00, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0001_0000}
   };
   localparam string TAGS [NV] = '{"R5", "R5", "R6", "R2", "R7", "R7", "R4", "R10", "R11", "R10", "R2"};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [31:0]     pc_next = '0;
   logic            boundary = 1'b0, ext_irq = 1'b0, reset_req = 1'b0, rfi = 1'b0;
   logic [NS-1:0]   sync_req = '0;
   logic [NS*CW-1:0] sync_cause = {4'd9, 4'd7, 4'd3};
   logic            reg_wr = 1'b0;
   logic [1:0]      reg_sel = 2'd0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata, msr, target_pc;
   logic            redirect;

   int n_run = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   trap_ctl #(
      .XLEN(XLEN), .EE_BIT(16), .N_SYNC(NS), .CAUSE_W(CW),
      .RESET_CAUSE(1), .EXT_CAUSE(5), .VEC_BASE(32'hFFF0_0000),
      .CLR_MASK(32'h0001_0010), .MSR_RST(32'h0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pc_next(pc_next), .boundary(boundary),
      .ext_irq(ext_irq), .reset_req(reset_req), .sync_req(sync_req),
      .sync_cause(sync_cause), .rfi(rfi), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msr(msr),
      .redirect(redirect), .target_pc(target_pc)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic read_reg(input logic [1:0] s, output logic [31:0] d);
      reg_sel = s;
      #1 d = reg_rdata;
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_run++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 msr", msr, 32'h0);
      check("R1 redirect", {31'b0, redirect}, 32'h0);
      read_reg(2'd1, rd); check("R1 sav0", rd, 32'h0);
      read_reg(2'd2, rd); check("R1 sav1", rd, 32'h0);

      for (int i = 0; i < NV; i++) begin
         write_reg(2'd0, VECS[i].msr_i);
         write_reg(2'd1, K0);
         write_reg(2'd2, K1);
         pc_next = VECS[i].pc; boundary = VECS[i].bnd; ext_irq = VECS[i].ext;
         reset_req = VECS[i].rreq; sync_req = VECS[i].sreq; rfi = VECS[i].rfi;
         @(negedge clk);
         boundary = 1'b0; ext_irq = 1'b0; reset_req = 1'b0; sync_req = '0; rfi = 1'b0;
         check({TAGS[i], " R9 redirect"}, {31'b0, redirect}, {31'b0, VECS[i].redir});
         if (VECS[i].redir) check({TAGS[i], " R8 target"}, target_pc, VECS[i].tgt);
         check({TAGS[i], " R4 msr"}, msr, VECS[i].msr_e);
         read_reg(2'd1, rd); check({TAGS[i], " R3 sav0"}, rd, VECS[i].take ? VECS[i].pc : K0);
         read_reg(2'd2, rd); check({TAGS[i], " R3 sav1"}, rd, VECS[i].take ? VECS[i].msr_i : K1);
      end

      // R9: redirect drops after one cycle
      write_reg(2'd0, 32'h0001_0000);
      boundary = 1'b1; ext_irq = 1'b1; pc_next = 32'hC00;
      @(negedge clk);
      boundary = 1'b0; ext_irq = 1'b0;
      check("R9 pulse high", {31'b0, redirect}, 32'h1);
      @(negedge clk);
      check("R9 pulse low", {31'b0, redirect}, 32'h0);

      // R12: write during entry discarded
      reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'hDEAD_0000;
      boundary = 1'b1; reset_req = 1'b1; pc_next = 32'h200;
      @(negedge clk);
      reg_wr = 1'b0; boundary = 1'b0; reset_req = 1'b0;
      read_reg(2'd1, rd); check("R12 write dropped", rd, 32'h200);

      // R12: plain write lands, select 3 reads zero
      write_reg(2'd1, 32'h0000_1234);
      read_reg(2'd1, rd); check("R12 write lands", rd, 32'h0000_1234);
      read_reg(2'd3, rd); check("R12 sel3 zero", rd, 32'h0);

      finish_run();
   end
endmodule